// File: doc/BRIEF.md
# AUX Reply Timeout Timer

This block times the wait for a reply on a DisplayPort-style AUX channel. The permitted wait is held in a compact encoding: a 7-bit length and a 2-bit unit code. The unit code picks a step of 8, 16, 32 or 64 microseconds. A configure strobe carries a requested wait in microseconds. The block chooses the smallest unit whose range covers the request, rounds the length up, and clamps it. In the same cycle it reports the wait that the encoding it replaces stood for.

A start strobe marks the end of a request. The timer then loads length × unit and counts it down, one step per microsecond tick. A reply-detected strobe stops the count. If the count runs out first, the block raises a single-cycle timeout pulse. Line signalling and reply decoding belong to neighbouring logic.

Top module: `aux_reply_timer`

## Requirements
- R1: After reset, `timeout_pulse` and `prev_us` are 0. The stored encoding is unit code 0 with length 69, a wait of 552 µs.
- R2: The unit code depends on the range of a non-zero request. Up to 1016 µs gives code 0 (8 µs unit), up to 2032 gives code 1 (16 µs), up to 4064 gives code 2 (32 µs), and anything above gives code 3 (64 µs).
- R3: The length is the request divided by the chosen unit. It is rounded up whenever the division leaves a remainder.
- R4: The length never exceeds 127. A request that would need more is stored as 127, so no stored wait is above 8128 µs.
- R5: A request of 0 µs stores the default encoding, code 0 with length 69 (552 µs).
- R6: On the clock edge that samples `cfg_valid`, `prev_us` takes the value length × unit of the encoding held before that edge, and the new encoding is stored. At all other times `prev_us` holds its value.
- R7: `start` loads length × unit of the currently stored encoding. `timeout_pulse` is high for exactly one cycle, in the cycle after the edge that samples the last required tick.
- R8: Cycles without `us_tick` do not advance the count. Ticks while the timer is idle have no effect and never produce a pulse.
- R9: `reply_seen` stops a running count with no pulse. This also holds when it arrives together with the final tick. Later ticks then have no effect.
- R10: `start` during a running count restarts it from the full value. The pulse then comes after that full number of further ticks.
- R11: A configure during a count, or in the same cycle as `start`, affects only later starts. The running count keeps the value it loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per elapsed microsecond |
| cfg_valid | input | 1 | Configure strobe |
| cfg_us | input | REQ_W | Requested timeout in microseconds |
| start | input | 1 | Request finished; begin countdown |
| reply_seen | input | 1 | Reply detected; stop countdown |
| timeout_pulse | output | 1 | One-cycle timeout indication |
| prev_us | output | 13 | Timeout in µs of the encoding replaced by the last configure |

## Verification
The bench builds the block with its default parameters: a 16-bit request field, a 1016 µs range step, a length cap of 127 and a default length of 69. The 16-bit request reaches every unit code, each range boundary on both sides, and requests far beyond the 8128 µs clamp. The countdowns cover the default wait, a one-unit wait and the full clamped wait. Ticks arrive both densely and with random gaps, so the timing of the pulse, the suppression by a reply and the restart are all exercised at their exact tick counts.

// File: rtl/aux_tmr_pkg.sv
package aux_tmr_pkg;

    // encoding field widths
    localparam int unsigned LEN_W       = 7;
    localparam int unsigned CODE_W      = 2;
    // log2 of the smallest unit (8 us)
    localparam int unsigned UNIT_SHIFT0 = 3;
    // width of a span in microseconds: length shifted by the largest unit
    localparam int unsigned SPAN_W      = LEN_W + UNIT_SHIFT0 + (1 << CODE_W) - 1;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [LEN_W-1:0]  len;
    } tmr_enc_t;

endpackage

// File: rtl/aux_tmr_encode.sv
module aux_tmr_encode
    import aux_tmr_pkg::*;
#(
    parameter int unsigned REQ_W   = 16,
    parameter int unsigned STEP    = 1016,
    parameter int unsigned LEN_CAP = 127,
    parameter int unsigned DEF_LEN = 69
) (
    input  logic [REQ_W-1:0] req_us,
    output tmr_enc_t         enc
);

    localparam int unsigned NCODES = 1 << CODE_W;
    localparam int unsigned RW1    = REQ_W + 1;

    always_comb begin
        logic [CODE_W-1:0] code;
        logic [REQ_W-1:0]  quo;
        logic [REQ_W-1:0]  mask;
        logic              rem;
        logic [RW1-1:0]    rounded;

        // smallest unit whose range covers the request
        code = CODE_W'(NCODES - 1);
        for (int c = NCODES - 2; c >= 0; c--) begin
            if (32'(req_us) <= (STEP << c)) begin
                code = CODE_W'(c);
            end
        end

        quo     = req_us >> (UNIT_SHIFT0 + 32'(code));
        mask    = (REQ_W'(1) << (UNIT_SHIFT0 + 32'(code))) - REQ_W'(1);
        rem     = |(req_us & mask);
        rounded = {1'b0, quo} + RW1'(rem);

        if (req_us == '0) begin
            enc.code = '0;
            enc.len  = LEN_W'(DEF_LEN);
        end else if (rounded > RW1'(LEN_CAP)) begin
            enc.code = code;
            enc.len  = LEN_W'(LEN_CAP);
        end else begin
            enc.code = code;
            enc.len  = rounded[LEN_W-1:0];
        end
    end

endmodule

// File: rtl/aux_tmr_span.sv
module aux_tmr_span
    import aux_tmr_pkg::*;
(
    input  tmr_enc_t          enc,
    output logic [SPAN_W-1:0] span_us
);

    // length times the unit selected by the code
    assign span_us = SPAN_W'(enc.len) << (UNIT_SHIFT0 + 32'(enc.code));

endmodule

// File: rtl/aux_tmr_count.sv
module aux_tmr_count
    import aux_tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    input  logic              reply,
    input  logic [SPAN_W-1:0] load_us,
    output logic              fire
);

    typedef struct packed {
        logic              run;
        logic [SPAN_W-1:0] left;
        logic              fire;
    } cnt_s;

    cnt_s cnt_d, cnt_q;

    always_comb begin
        cnt_d      = cnt_q;
        cnt_d.fire = 1'b0;
        if (start) begin
            cnt_d.run  = 1'b1;
            cnt_d.left = load_us;
        end else if (cnt_q.run) begin
            if (reply) begin
                cnt_d.run = 1'b0;
            end else if (tick) begin
                if (cnt_q.left <= SPAN_W'(1)) begin
                    cnt_d.left = '0;
                    cnt_d.run  = 1'b0;
                    cnt_d.fire = 1'b1;
                end else begin
                    cnt_d.left = cnt_q.left - SPAN_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign fire = cnt_q.fire;

endmodule

// File: rtl/aux_reply_timer.sv
module aux_reply_timer
    import aux_tmr_pkg::*;
#(
    parameter int unsigned REQ_W   = 16,
    parameter int unsigned STEP    = 1016,
    parameter int unsigned LEN_CAP = 127,
    parameter int unsigned DEF_LEN = 69
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              cfg_valid,
    input  logic [REQ_W-1:0]  cfg_us,
    input  logic              start,
    input  logic              reply_seen,
    output logic              timeout_pulse,
    output logic [SPAN_W-1:0] prev_us
);

    typedef struct packed {
        tmr_enc_t          enc;
        logic [SPAN_W-1:0] prev;
    } top_s;

    localparam top_s RST_STATE = '{
        enc:  '{code: '0, len: LEN_W'(DEF_LEN)},
        prev: '0
    };

    top_s              top_d, top_q;
    tmr_enc_t          new_enc;
    logic [SPAN_W-1:0] cur_span;

    aux_tmr_encode #(
        .REQ_W  (REQ_W),
        .STEP   (STEP),
        .LEN_CAP(LEN_CAP),
        .DEF_LEN(DEF_LEN)
    ) u_encode (
        .req_us(cfg_us),
        .enc   (new_enc)
    );

    aux_tmr_span u_span (
        .enc    (top_q.enc),
        .span_us(cur_span)
    );

    always_comb begin
        top_d = top_q;
        if (cfg_valid) begin
            top_d.prev = cur_span;
            top_d.enc  = new_enc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= RST_STATE;
        end else begin
            top_q <= top_d;
        end
    end

    aux_tmr_count u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .tick   (us_tick),
        .reply  (reply_seen),
        .load_us(cur_span),
        .fire   (timeout_pulse)
    );

    assign prev_us = top_q.prev;

endmodule

// File: rtl/aux_reply_timer_chk.sv
module aux_reply_timer_chk
    import aux_tmr_pkg::*;
#(
    parameter int unsigned LEN_CAP = 127
) (
    input logic              clk,
    input logic              rst_n,
    input logic              us_tick,
    input logic              cfg_valid,
    input logic              start,
    input logic              reply_seen,
    input logic              timeout_pulse,
    input logic [SPAN_W-1:0] prev_us
);

    localparam int unsigned MAX_SPAN = LEN_CAP << (UNIT_SHIFT0 + (1 << CODE_W) - 1);

    // R7
    pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |=> !timeout_pulse);

    // R9
    reply_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reply_seen && !start) |=> !timeout_pulse);

    // R6
    prev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> $stable(prev_us));

    // R8
    tick_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !us_tick |=> !timeout_pulse);

    // R10
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !timeout_pulse);

    // R4
    prev_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> (32'(prev_us) <= MAX_SPAN));

endmodule

bind aux_reply_timer aux_reply_timer_chk #(
    .LEN_CAP(LEN_CAP)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .us_tick      (us_tick),
    .cfg_valid    (cfg_valid),
    .start        (start),
    .reply_seen   (reply_seen),
    .timeout_pulse(timeout_pulse),
    .prev_us      (prev_us)
);

// File: tb/test_aux_reply_timer.sv
module test_aux_reply_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic        cfg_valid = 1'b0;
    logic [15:0] cfg_us = '0;
    logic        start = 1'b0;
    logic        reply_seen = 1'b0;
    logic        timeout_pulse;
    logic [12:0] prev_us;

    int checks = 0;
    int fails = 0;
    int pulse_seen = 0;
    int model_span = 552;

    always #5 clk = ~clk;

    aux_reply_timer i_aux_reply_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .us_tick      (us_tick),
        .cfg_valid    (cfg_valid),
        .cfg_us       (cfg_us),
        .start        (start),
        .reply_seen   (reply_seen),
        .timeout_pulse(timeout_pulse),
        .prev_us      (prev_us)
    );

    always @(negedge clk) if (timeout_pulse) pulse_seen++;

    function automatic int exp_span(int us);
        int unit;
        int len;
        if (us == 0) return 552;
        if (us <= 1016) unit = 8;
        else if (us <= 2032) unit = 16;
        else if (us <= 4064) unit = 32;
        else unit = 64;
        len = (us + unit - 1) / unit;
        if (len > 127) len = 127;
        return len * unit;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    // configure and check the reported previous span
    task automatic do_cfg(int us, string req);
        @(negedge clk);
        cfg_valid = 1'b1;
        cfg_us = 16'(us);
        @(negedge clk);
        cfg_valid = 1'b0;
        check(32'(prev_us) == model_span, req, 32'(prev_us), model_span);
        model_span = exp_span(us);
    endtask

    task automatic do_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_ticks(int n, bit dense, bit reply_last);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!dense) begin
                while ($urandom % 3 == 0) begin
                    us_tick = 1'b0;
                    reply_seen = 1'b0;
                    @(negedge clk);
                end
            end
            us_tick = 1'b1;
            reply_seen = reply_last && (i == n - 1);
        end
        @(negedge clk);
        us_tick = 1'b0;
        reply_seen = 1'b0;
    endtask

    // full countdown: no pulse after n-1 ticks, one pulse after n
    task automatic run_full(int n, bit dense, string req);
        pulse_seen = 0;
        do_start();
        if (n > 1) do_ticks(n - 1, dense, 1'b0);
        settle();
        check(pulse_seen == 0, req, pulse_seen, 0);
        do_ticks(1, dense, 1'b0);
        settle();
        settle();
        check(pulse_seen == 1, req, pulse_seen, 1);
    endtask

    initial begin
        int dir_vals[15] = '{1, 7, 8, 9, 1016, 1017, 2032, 2033, 4064, 4065,
                             8128, 8129, 65535, 0, 300};
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1 reset state
        check(timeout_pulse == 1'b0, "R1 pulse", 32'(timeout_pulse), 0);
        check(prev_us == 13'd0, "R1 prev", 32'(prev_us), 0);
        // R1 default encoding times out after 552 ticks
        run_full(552, 1'b1, "R1/R7 default count");
        // R8 idle ticks do nothing
        pulse_seen = 0;
        do_ticks(40, 1'b1, 1'b0);
        settle();
        check(pulse_seen == 0, "R8 idle ticks", pulse_seen, 0);
        // R2 R3 R4 R5 R6 directed boundaries
        foreach (dir_vals[k]) begin
            do_cfg(dir_vals[k], "R2/R3/R4/R5/R6 directed prev");
        end
        // R6 random configures
        for (int k = 0; k < 60; k++) begin
            int v;
            case ($urandom % 4)
                0: v = $urandom % 1100;
                1: v = $urandom % 4200;
                2: v = $urandom % 9000;
                default: v = $urandom % 65536;
            endcase
            do_cfg(v, "R6 random prev");
        end
        // R7 one-unit wait
        do_cfg(5, "R3 small");
        run_full(8, 1'b0, "R7 short count");
        // R4 clamped max wait
        do_cfg(20000, "R4 clamp");
        run_full(8128, 1'b1, "R4/R7 max count");
        // R8 sparse ticks, random spans
        for (int k = 0; k < 4; k++) begin
            do_cfg($urandom % 1500, "R6 random prev");
            run_full(model_span, 1'b0, "R8 sparse count");
        end
        // R9 reply mid-count
        do_cfg(100, "R6 prev");
        pulse_seen = 0;
        do_start();
        do_ticks(50, 1'b0, 1'b1);
        do_ticks(200, 1'b1, 1'b0);
        settle();
        check(pulse_seen == 0, "R9 reply mid", pulse_seen, 0);
        // R9 reply on the final tick
        pulse_seen = 0;
        do_start();
        do_ticks(104, 1'b1, 1'b1);
        do_ticks(20, 1'b1, 1'b0);
        settle();
        check(pulse_seen == 0, "R9 reply last tick", pulse_seen, 0);
        // R10 restart
        pulse_seen = 0;
        do_start();
        do_ticks(100, 1'b1, 1'b0);
        run_full(104, 1'b1, "R10 restart");
        // R11 configure during count keeps loaded value
        pulse_seen = 0;
        do_start();
        do_ticks(30, 1'b1, 1'b0);
        do_cfg(2000, "R11 prev");
        do_ticks(73, 1'b0, 1'b0);
        settle();
        check(pulse_seen == 0, "R11 early", pulse_seen, 0);
        do_ticks(1, 1'b1, 1'b0);
        settle();
        settle();
        check(pulse_seen == 1, "R11 loaded value", pulse_seen, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
        $finish;
    end

endmodule